// File: doc/BRIEF.md
# Serial SRAM Loader with Bus Handover

This block sits between a 64K-byte SRAM, a small 8-bit CPU and an external host that has only a few spare wires. While the select input is low, the host owns the buses. It clocks bytes in serially and strobes the current byte into an address-high or address-low register. The address then stays put while the next byte is shifted in as data, and a write strobe stores that byte in the SRAM. The CPU is kept off the buses the whole time.

Raising the select input hands the buses to the CPU. The CPU address goes through a capture register that is frozen while PHI2 is high. The CPU read/write line and PHI2 drive the SRAM write enable and chip select through a multiplexer, so neither side's control lines are ever tri-stated. A decoder on the top address bits also produces an active-low peripheral write strobe. It listens alongside the SRAM and does not block SRAM access.

All host lines are asynchronous. Each passes through a two-stage synchroniser and an edge detector before it is used.

Top module: `serial_sram_loader`

## Requirements
- R1: On each rising edge of the shift clock, the serial bit enters the shift register at the LSB end, so the first bit sent ends up as the MSB. The parallel data byte changes only on a rising edge of the output latch, which copies the whole shift register.
- R2: A rising edge of the high or low address strobe copies the current data byte into bits 15:8 or 7:0 of the loader address. Shifting or latching a new data byte leaves the loader address unchanged.
- R3: In loader mode, each rising edge of the write strobe gives exactly one system-clock cycle in which the SRAM write enable and chip select are both low. During that cycle the data byte is on the data bus and the latched address is on the address bus.
- R4: With select low (loader mode), the loader drives the address and data buses. The CPU address and data enables are both 0.
- R5: With select high (CPU mode), the address bus carries the captured CPU address. The loader enables are 0, the SRAM write enable follows CPU read/write, and the SRAM chip select is the inverse of PHI2. The CPU data enable is 1 only when read/write is 0.
- R6: The CPU address register loads on every system clock while PHI2 is low and holds its value while PHI2 is high.
- R7: The peripheral write strobe is 0 exactly when CPU mode is selected, captured address bits 15:14 are 01, read/write is 0 and PHI2 is 1. SRAM write enable and chip select behave the same whether or not this strobe is asserted.
- R8: After reset, all loader registers and the CPU address register are 0. In loader mode the SRAM write enable and chip select are then 1.
- R9: The effect of a host pin transition appears in the outputs after the second rising system-clock edge following the first edge that samples the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSer | input | 1 | Serial data bit from host |
| hostSck | input | 1 | Host shift clock |
| hostLatch | input | 1 | Host output latch, copies shift register to data byte |
| hostAddrHi | input | 1 | Host strobe: load data byte as address high byte |
| hostAddrLo | input | 1 | Host strobe: load data byte as address low byte |
| hostWr | input | 1 | Host memory write strobe |
| busSel | input | 1 | 0 = loader owns buses, 1 = CPU owns buses |
| cpuAddr | input | 16 | CPU address lines |
| cpuRw | input | 1 | CPU read/write (1 = read) |
| cpuPhi2 | input | 1 | CPU PHI2 phase |
| cpuWrData | input | 8 | CPU write data |
| addrBus | output | 16 | Address bus to SRAM |
| dataBus | output | 8 | Data bus value from the selected side |
| loaderAddrEn | output | 1 | Loader address drivers active |
| cpuAddrEn | output | 1 | CPU address register drivers active |
| loaderDataEn | output | 1 | Loader data driver active |
| cpuDataEn | output | 1 | CPU data drivers active |
| sramWeN | output | 1 | SRAM write enable, active low |
| sramCsN | output | 1 | SRAM chip select, active low |
| perWrN | output | 1 | Peripheral write strobe, active low |

## Verification
A host pin level that is set before clock edge k first affects the registers at edge k+2. The loader write pulse covers the interval between edges k+1 and k+2. Select, read/write, PHI2 and the CPU data reach the outputs in the same cycle. The captured CPU address follows the cpuAddr present at the last edge where PHI2 was low. The bench reference model keeps a three-deep history of every host pin, taken at each rising edge. It fires each event from the second and third entries of that history and compares every output 2 ns after each rising edge, when both the registered and the combinational paths have settled. The SRAM stand-in writes at that same point, so the bytes read back by the CPU depend on the correct write cycle and address.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  // strobes from the synchronising control into the datapath
  typedef struct packed {
    logic shift;
    logic serBit;
    logic latchData;
    logic loadHi;
    logic loadLo;
    logic memWr;
  } ldrStrobe_t;
endpackage

// File: rtl/ldr_ctrl.sv
module ldr_ctrl
  import ldr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostSer,
  input  logic       hostSck,
  input  logic       hostLatch,
  input  logic       hostAddrHi,
  input  logic       hostAddrLo,
  input  logic       hostWr,
  output ldrStrobe_t strb
);
  localparam int unsigned N_PINS = 6;

  logic [N_PINS-1:0] rawPins;
  logic [N_PINS-1:0] syncOut;
  logic [N_PINS-1:0] prevQ;
  logic [N_PINS-1:0] rise;

  assign rawPins = {hostWr, hostAddrLo, hostAddrHi, hostLatch, hostSck, hostSer};

  generate
    if (SYNC_STAGES > 1) begin : gMulti
      logic [SYNC_STAGES-1:0][N_PINS-1:0] stageQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= '0;
        else       stageQ <= {stageQ[SYNC_STAGES-2:0], rawPins};
      end
      assign syncOut = stageQ[SYNC_STAGES-1];
    end else begin : gSingle
      logic [N_PINS-1:0] stageQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= '0;
        else       stageQ <= rawPins;
      end
      assign syncOut = stageQ;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncOut;
  end

  assign rise = syncOut & ~prevQ;

  always_comb begin
    strb.serBit    = syncOut[0];
    strb.shift     = rise[1];
    strb.latchData = rise[2];
    strb.loadHi    = rise[3];
    strb.loadLo    = rise[4];
    strb.memWr     = rise[5];
  end
endmodule

// File: rtl/ldr_datapath.sv
module ldr_datapath
  import ldr_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 2 * DATA_W,
  parameter int unsigned PER_BITS  = 2,
  parameter int unsigned PER_MATCH = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldrStrobe_t        strb,
  input  logic              busSel,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRw,
  input  logic              cpuPhi2,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [ADDR_W-1:0] addrBus,
  output logic [DATA_W-1:0] dataBus,
  output logic              loaderAddrEn,
  output logic              cpuAddrEn,
  output logic              loaderDataEn,
  output logic              cpuDataEn,
  output logic              sramWeN,
  output logic              sramCsN,
  output logic              perWrN
);
  localparam int unsigned HALF_W = ADDR_W / 2;

  logic [DATA_W-1:0] shiftQ;
  logic [DATA_W-1:0] dataQ;
  logic [HALF_W-1:0] addrHiQ;
  logic [HALF_W-1:0] addrLoQ;
  logic [ADDR_W-1:0] cpuAddrQ;
  logic              perHit;

  // loader side: serial in, parallel byte, two address bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      dataQ   <= '0;
      addrHiQ <= '0;
      addrLoQ <= '0;
    end else begin
      if (strb.shift)     shiftQ  <= {shiftQ[DATA_W-2:0], strb.serBit};
      if (strb.latchData) dataQ   <= shiftQ;
      if (strb.loadHi)    addrHiQ <= HALF_W'(dataQ);
      if (strb.loadLo)    addrLoQ <= HALF_W'(dataQ);
    end
  end

  // CPU side: follows while PHI2 low, frozen while PHI2 high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cpuAddrQ <= '0;
    else if (!cpuPhi2) cpuAddrQ <= cpuAddr;
  end

  assign perHit = (cpuAddrQ[ADDR_W-1 -: PER_BITS] == PER_BITS'(PER_MATCH));

  always_comb begin
    loaderAddrEn = ~busSel;
    cpuAddrEn    = busSel;
    loaderDataEn = ~busSel;
    cpuDataEn    = busSel & ~cpuRw;
    if (busSel) begin
      addrBus = cpuAddrQ;
      dataBus = cpuWrData;
      sramWeN = cpuRw;
      sramCsN = ~cpuPhi2;
    end else begin
      addrBus = {addrHiQ, addrLoQ};
      dataBus = dataQ;
      sramWeN = ~strb.memWr;
      sramCsN = ~strb.memWr;
    end
    perWrN = ~(busSel & perHit & ~cpuRw & cpuPhi2);
  end
endmodule

// File: rtl/serial_sram_loader.sv
module serial_sram_loader
  import ldr_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 2 * DATA_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PER_BITS    = 2,
  parameter int unsigned PER_MATCH   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSer,
  input  logic              hostSck,
  input  logic              hostLatch,
  input  logic              hostAddrHi,
  input  logic              hostAddrLo,
  input  logic              hostWr,
  input  logic              busSel,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRw,
  input  logic              cpuPhi2,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [ADDR_W-1:0] addrBus,
  output logic [DATA_W-1:0] dataBus,
  output logic              loaderAddrEn,
  output logic              cpuAddrEn,
  output logic              loaderDataEn,
  output logic              cpuDataEn,
  output logic              sramWeN,
  output logic              sramCsN,
  output logic              perWrN
);
  ldrStrobe_t strb;

  ldr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .hostSer(hostSer), .hostSck(hostSck),
    .hostLatch(hostLatch), .hostAddrHi(hostAddrHi), .hostAddrLo(hostAddrLo),
    .hostWr(hostWr), .strb(strb)
  );

  ldr_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PER_BITS(PER_BITS), .PER_MATCH(PER_MATCH)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busSel(busSel), .cpuAddr(cpuAddr),
    .cpuRw(cpuRw), .cpuPhi2(cpuPhi2), .cpuWrData(cpuWrData), .addrBus(addrBus),
    .dataBus(dataBus), .loaderAddrEn(loaderAddrEn), .cpuAddrEn(cpuAddrEn),
    .loaderDataEn(loaderDataEn), .cpuDataEn(cpuDataEn), .sramWeN(sramWeN),
    .sramCsN(sramCsN), .perWrN(perWrN)
  );
endmodule

// File: rtl/ssl_checker.sv
module ssl_checker
  import ldr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input ldrStrobe_t        strb,
  input logic              busSel,
  input logic              cpuRw,
  input logic              cpuPhi2,
  input logic [ADDR_W-1:0] addrBus,
  input logic [DATA_W-1:0] dataBus,
  input logic              loaderAddrEn,
  input logic              cpuAddrEn,
  input logic              loaderDataEn,
  input logic              cpuDataEn,
  input logic              sramWeN,
  input logic              sramCsN,
  input logic              perWrN
);
  assert_data_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busSel && $past(!busSel) && !$past(strb.latchData)) |-> $stable(dataBus));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busSel && $past(!busSel) && !$past(strb.loadHi) && !$past(strb.loadLo))
      |-> $stable(addrBus));

  assert_single_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.memWr |=> !strb.memWr);

  assert_we_with_cs_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busSel && !sramWeN) |-> !sramCsN);

  assert_one_addr_driver_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(loaderAddrEn && cpuAddrEn));

  assert_one_data_driver_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(loaderDataEn && cpuDataEn));

  assert_phi2_addr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && $past(busSel) && cpuPhi2 && $past(cpuPhi2)) |-> $stable(addrBus));

  assert_per_qualified_R7: assert property (@(posedge clk) disable iff (!rstN)
    !perWrN |-> (busSel && cpuPhi2 && !cpuRw));
endmodule

bind serial_sram_loader ssl_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .strb(strb), .busSel(busSel), .cpuRw(cpuRw),
  .cpuPhi2(cpuPhi2), .addrBus(addrBus), .dataBus(dataBus),
  .loaderAddrEn(loaderAddrEn), .cpuAddrEn(cpuAddrEn), .loaderDataEn(loaderDataEn),
  .cpuDataEn(cpuDataEn), .sramWeN(sramWeN), .sramCsN(sramCsN), .perWrN(perWrN)
);

// File: tb/serial_sram_loader_tb_top.sv
`timescale 1ns/1ps
module serial_sram_loader_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSer = 0, hostSck = 0, hostLatch = 0, hostAddrHi = 0, hostAddrLo = 0, hostWr = 0;
  logic busSel = 0;
  logic [15:0] cpuAddr = '0;
  logic cpuRw = 1'b1, cpuPhi2 = 1'b0;
  logic [7:0] cpuWrData = '0;
  logic [15:0] addrBus;
  logic [7:0] dataBus;
  logic loaderAddrEn, cpuAddrEn, loaderDataEn, cpuDataEn, sramWeN, sramCsN, perWrN;

  int nChecks = 0;
  int nFail = 0;
  bit perSeen = 0;
  bit perSeenBad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_sram_loader dut_i (
    .clk(clk), .rstN(rstN), .hostSer(hostSer), .hostSck(hostSck), .hostLatch(hostLatch),
    .hostAddrHi(hostAddrHi), .hostAddrLo(hostAddrLo), .hostWr(hostWr), .busSel(busSel),
    .cpuAddr(cpuAddr), .cpuRw(cpuRw), .cpuPhi2(cpuPhi2), .cpuWrData(cpuWrData),
    .addrBus(addrBus), .dataBus(dataBus), .loaderAddrEn(loaderAddrEn), .cpuAddrEn(cpuAddrEn),
    .loaderDataEn(loaderDataEn), .cpuDataEn(cpuDataEn), .sramWeN(sramWeN),
    .sramCsN(sramCsN), .perWrN(perWrN)
  );

  // behavioural SRAM stand-in
  logic [7:0] mem [0:65535];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: pin history h[0]=newest, events fire from h[1] & ~h[2]
  logic [2:0] hSer, hSck, hLat, hHi, hLo, hWr;
  logic [7:0] mShift, mData, mHi, mLo;
  logic [15:0] mCpuAddr;

  always @(posedge clk) begin
    logic [7:0] oldShift, oldData;
    logic memWrNow;
    logic [15:0] eAddr;
    logic [7:0] eData;
    logic eWe, eCs, ePer;
    if (!rstN) begin
      {hSer, hSck, hLat, hHi, hLo, hWr} = '0;
      mShift = 0; mData = 0; mHi = 0; mLo = 0; mCpuAddr = 0;
    end else begin
      oldShift = mShift;
      oldData  = mData;
      if (hSck[1] && !hSck[2]) mShift = {oldShift[6:0], hSer[1]};
      if (hLat[1] && !hLat[2]) mData = oldShift;
      if (hHi[1] && !hHi[2])   mHi = oldData;
      if (hLo[1] && !hLo[2])   mLo = oldData;
      if (!cpuPhi2)            mCpuAddr = cpuAddr;
      hSer = {hSer[1:0], hostSer};   hSck = {hSck[1:0], hostSck};
      hLat = {hLat[1:0], hostLatch}; hHi  = {hHi[1:0], hostAddrHi};
      hLo  = {hLo[1:0], hostAddrLo}; hWr  = {hWr[1:0], hostWr};
    end
    #2;
    if (!done) begin
      memWrNow = hWr[1] && !hWr[2];
      eAddr = busSel ? mCpuAddr : {mHi, mLo};
      eData = busSel ? cpuWrData : mData;
      eWe   = busSel ? cpuRw : !memWrNow;
      eCs   = busSel ? !cpuPhi2 : !memWrNow;
      ePer  = !(busSel && mCpuAddr[15:14] == 2'b01 && !cpuRw && cpuPhi2);
      check(busSel ? "R5/R6 addrBus" : "R2/R4 addrBus", 32'(addrBus), 32'(eAddr));
      check(busSel ? "R5 dataBus" : "R1 dataBus", 32'(dataBus), 32'(eData));
      check(busSel ? "R5 sramWeN" : "R3/R9 sramWeN", 32'(sramWeN), 32'(eWe));
      check(busSel ? "R5 sramCsN" : "R3/R9 sramCsN", 32'(sramCsN), 32'(eCs));
      check("R4/R5 enables", 32'({loaderAddrEn, cpuAddrEn, loaderDataEn, cpuDataEn}),
            32'({!busSel, busSel, !busSel, busSel && !cpuRw}));
      check("R7 perWrN", 32'(perWrN), 32'(ePer));
      if (!perWrN && addrBus[15:14] == 2'b01) perSeen = 1;
      if (!perWrN && addrBus[15:14] != 2'b01) perSeenBad = 1;
      if (rstN && !sramCsN && !sramWeN) mem[addrBus] = dataBus;
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      hostSer = b[i]; waitN(4);
      hostSck = 1'b1; waitN(4);
      hostSck = 1'b0; waitN(4);
    end
    hostLatch = 1'b1; waitN(4);
    hostLatch = 1'b0; waitN(4);
  endtask

  task automatic loadByte(input logic [15:0] a, input logic [7:0] d);
    shiftByte(a[15:8]);
    hostAddrHi = 1'b1; waitN(4); hostAddrHi = 1'b0; waitN(4);
    shiftByte(a[7:0]);
    hostAddrLo = 1'b1; waitN(4); hostAddrLo = 1'b0; waitN(4);
    shiftByte(d);
    hostWr = 1'b1; waitN(4); hostWr = 1'b0; waitN(4);
  endtask

  // CPU stand-in: address in phase 1, PHI2 high for two clocks
  task automatic cpuCycle(input logic [15:0] a, input logic rw, input logic [7:0] wd,
                          input logic [7:0] expRd, input string tag);
    cpuAddr = a; cpuRw = rw; cpuWrData = wd; cpuPhi2 = 1'b0;
    waitN(2);
    cpuPhi2 = 1'b1;
    waitN(1);
    if (rw) check(tag, 32'(mem[addrBus]), 32'(expRd));
    else    check(tag, 32'(addrBus), 32'(a));
    waitN(1);
    cpuPhi2 = 1'b0; cpuRw = 1'b1;
    waitN(1);
  endtask

  initial begin
    waitN(3);
    // reset state R8
    check("R8 addrBus in reset", 32'(addrBus), 32'h0);
    check("R8 sramWeN in reset", 32'(sramWeN), 32'h1);
    rstN = 1'b1;
    waitN(2);
    check("R8 dataBus after reset", 32'(dataBus), 32'h0);

    // loader mode: reset vector, program bytes, boundary addresses
    loadByte(16'hFFFC, 8'h00);
    loadByte(16'hFFFD, 8'h02);
    loadByte(16'h0200, 8'hA9);
    loadByte(16'h0201, 8'h5A);
    loadByte(16'h0000, 8'hFF);
    loadByte(16'h4000, 8'h81);

    // R2: reshift a data byte, address must stay at 0x4000
    shiftByte(8'h3C);
    check("R2 address kept after reshift", 32'(addrBus), 32'h4000);
    check("R1 latched byte MSB first", 32'(dataBus), 32'h3C);

    check("R3 mem FFFC", 32'(mem[16'hFFFC]), 32'h00);
    check("R3 mem FFFD", 32'(mem[16'hFFFD]), 32'h02);
    check("R3 mem 0200", 32'(mem[16'h0200]), 32'hA9);
    check("R3 mem 0000", 32'(mem[16'h0000]), 32'hFF);

    // hand over to CPU
    busSel = 1'b1;
    waitN(2);
    check("R4 loader off in CPU mode", 32'({loaderAddrEn, loaderDataEn}), 32'h0);
    cpuCycle(16'hFFFC, 1'b1, 8'h00, 8'h00, "R5 read FFFC");
    cpuCycle(16'hFFFD, 1'b1, 8'h00, 8'h02, "R5 read FFFD");
    cpuCycle(16'h0200, 1'b1, 8'h00, 8'hA9, "R5 read 0200");
    cpuCycle(16'h0201, 1'b1, 8'h00, 8'h5A, "R5 read 0201");
    cpuCycle(16'h4000, 1'b1, 8'h00, 8'h81, "R5 read 4000");
    cpuCycle(16'h3FFF, 1'b0, 8'h11, 8'h00, "R7 write below window");
    cpuCycle(16'h8000, 1'b0, 8'h22, 8'h00, "R7 write above window");
    check("R7 no strobe outside window", 32'(perSeen | perSeenBad), 32'h0);
    cpuCycle(16'h4123, 1'b0, 8'h77, 8'h00, "R7 write in window");
    check("R7 strobe seen in window", 32'(perSeen), 32'h1);
    cpuCycle(16'h7FFF, 1'b0, 8'h66, 8'h00, "R7 write top of window");
    check("R7 no strobe out of window", 32'(perSeenBad), 32'h0);
    cpuCycle(16'h4123, 1'b1, 8'h00, 8'h77, "R7 SRAM written under strobe");
    cpuCycle(16'h7FFF, 1'b1, 8'h00, 8'h66, "R7 SRAM top of window");
    cpuCycle(16'h3FFF, 1'b1, 8'h00, 8'h11, "R5 CPU write stored");

    // R6: change cpuAddr while PHI2 high; bus must hold
    cpuAddr = 16'h1234; cpuRw = 1'b1; cpuPhi2 = 1'b0; waitN(2);
    cpuPhi2 = 1'b1; waitN(1);
    cpuAddr = 16'hBEEF; waitN(2);
    check("R6 address frozen in PHI2 high", 32'(addrBus), 32'h1234);
    cpuPhi2 = 1'b0; waitN(2);
    check("R6 address follows in PHI2 low", 32'(addrBus), 32'hBEEF);

    // back to loader: address restored from loader registers
    busSel = 1'b0; waitN(2);
    check("R4 loader address back", 32'(addrBus), 32'h4000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule